// File: doc/BRIEF.md
# Paged On-Chip Data-Memory Access Controller

This block turns the two-cycle indirect data-memory moves of a small 8-bit CPU into accesses on either an on-chip RAM or an external byte-wide bus. The CPU gives only an 8-bit pointer. A page register supplies the upper byte of the 16-bit address. The page register is written directly, and it is also loaded whenever software writes the port register that drives the upper address pins. Writing either register therefore selects the page for the next move.

When the RAM enable bit is set and the page is at or above the window base, 0xF7 by default, the move is served by the internal RAM. All other moves go to the external bus, which has a 16-bit address, byte data with an output enable, and active-low read and write strobes. Internal moves leave both strobes inactive. When debug mode is on, an internal write also drives its data and address onto the external bus so that it can be observed.

The RAM has no reset, so its contents survive reset. A write that is hit by reset in its first cycle is dropped. A write that is hit by reset in its second cycle is committed.

Top module: `paged_xdata_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, ext_rd_n=1, ext_wr_n=1, ext_doe=0 and done=0. Reset clears the page register to 0x00, so the first move after reset goes out on the external bus at address {0x00, ptr}.
- R2: The move address is {page, ptr}. The move is internal only when xram_en=1 and page >= 0xF7. A page of 0xF6, or xram_en=0, sends the move to the external bus.
- R3: A pulse on sfr_port_we loads both port_q and the page register with sfr_wdata. A pulse on sfr_page_we loads only the page register and leaves port_q unchanged.
- R4: An external read drives ext_rd_n=0 and ext_wr_n=1 during both cycles, with ext_addr={page,ptr}. rdata takes ext_din at the end of the second cycle.
- R5: An external write drives ext_wr_n=0, ext_rd_n=1, ext_doe=1 and ext_dout=wdata during both cycles.
- R6: An internal move keeps ext_rd_n=1 and ext_wr_n=1. A byte written internally is returned by a later internal read of the same address.
- R7: With dbg_en=1, an internal write drives ext_doe=1 and ext_dout=wdata while both strobes stay inactive.
- R8: Reset seen at the end of the first cycle of an internal write leaves the old RAM value in place.
- R9: Reset seen at the end of the second cycle of an internal write stores the new value.
- R10: Reset does not alter the contents of the internal RAM.
- R11: done pulses high for exactly one cycle, two clocks after the clock that accepts req. A req raised while a move is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a move (sampled when idle) |
| wr_en | input | 1 | 1 = write move, 0 = read move |
| ptr | input | 8 | Low address byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with done |
| done | output | 1 | One-cycle end-of-move pulse |
| sfr_port_we | input | 1 | Write the port register (also loads the page) |
| sfr_page_we | input | 1 | Write the page register only |
| sfr_wdata | input | 8 | Data for the register writes |
| port_q | output | 8 | Port register value |
| xram_en | input | 1 | Enable for the internal RAM window |
| dbg_en | input | 1 | Debug mirroring of internal writes |
| ext_addr | output | 16 | External address |
| ext_dout | output | 8 | External write data |
| ext_doe | output | 1 | External data output enable |
| ext_din | input | 8 | External read data |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
Each move is raised for one clock at a falling edge. The bus outputs are registered, so they are due right after the accepting clock, and the bench samples them at the next falling edge. done and rdata arrive two clocks later, and the bench samples them at the third falling edge. A register write takes effect at the next clock, and its result is checked through ext_addr on the following move or through port_q. The reset-during-write cases raise rst at the falling edge just before the second or the third clock of the move.

// File: rtl/pxd_pkg.sv
package pxd_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_C1   = 2'd1,
    S_C2   = 2'd2
  } seq_e;
endpackage

// File: rtl/pxd_page_regs.sv
module pxd_page_regs #(
  parameter int DW = 8,
  parameter logic [DW-1:0] PORT_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          port_we,
  input  logic          page_we,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] page_q,
  output logic [DW-1:0] port_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      port_q <= PORT_RST;
    end else begin
      if (port_we) begin
        port_q <= din;
        page_q <= din;
      end else if (page_we) begin
        page_q <= din;
      end
    end
  end

  // R3: a port write reaches the page register too
  a_r3_port_loads_page: assert property (@(posedge clk) disable iff (rst)
    port_we |=> (page_q == $past(din)));
  // R3: a page-only write leaves the port register alone
  a_r3_page_keeps_port: assert property (@(posedge clk) disable iff (rst)
    (page_we && !port_we) |=> (port_q == $past(port_q)));
endmodule

// File: rtl/pxd_ram.sv
module pxd_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 2304,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // no reset on purpose: contents persist across reset (R10)
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pxd_seq.sv
module pxd_seq
  import pxd_pkg::*;
#(
  parameter int DW       = 8,
  parameter int WIN_BASE = 8'hF7,
  localparam int AW      = 2 * DW,
  localparam int DEPTH   = ((1 << DW) - WIN_BASE) << DW,
  localparam int IW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr_en,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] page,
  input  logic          xram_en,
  input  logic          dbg_en,
  input  logic [DW-1:0] ram_rdata,
  output logic [IW-1:0] ram_addr,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_dout,
  output logic          ext_doe,
  input  logic [DW-1:0] ext_din,
  output logic          rd_n,
  output logic          wr_n
);
  seq_e          state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          we_q;
  logic          hit_q;
  logic          hit_n;
  logic [DW-1:0] page_off;

  assign hit_n     = xram_en && (page >= DW'(WIN_BASE));
  assign page_off  = addr_q[AW-1:DW] - DW'(WIN_BASE);
  assign ram_addr  = IW'({page_off, addr_q[DW-1:0]});
  assign ram_wdata = wd_q;
  // not gated by rst: a reset in the second cycle still commits (R9)
  assign ram_we    = (state == S_C2) && we_q && hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr_q   <= '0;
      wd_q     <= '0;
      we_q     <= 1'b0;
      hit_q    <= 1'b0;
      rdata    <= '0;
      done     <= 1'b0;
      ext_addr <= '0;
      ext_dout <= '0;
      ext_doe  <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          addr_q   <= {page, ptr};
          wd_q     <= wdata;
          we_q     <= wr_en;
          hit_q    <= hit_n;
          ext_addr <= {page, ptr};
          ext_dout <= wdata;
          if (hit_n) begin
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            ext_doe <= dbg_en && wr_en;
          end else begin
            rd_n    <= wr_en;
            wr_n    <= !wr_en;
            ext_doe <= wr_en;
          end
          state <= S_C1;
        end
        S_C1: state <= S_C2;
        S_C2: begin
          state   <= S_IDLE;
          done    <= 1'b1;
          if (!we_q) rdata <= hit_q ? ram_rdata : ext_din;
          rd_n    <= 1'b1;
          wr_n    <= 1'b1;
          ext_doe <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: never both strobes at once
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R6: internal window moves keep strobes quiet
  a_r6_window_quiet: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && hit_q) |-> (rd_n && wr_n));
  // R5: write strobe only with the bus driven
  a_r5_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ext_doe);
  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11: second cycle is always followed by done
  a_r11_done_after_c2: assert property (@(posedge clk) disable iff (rst)
    (state == S_C2) |=> done);
endmodule

// File: rtl/paged_xdata_ctrl.sv
module paged_xdata_ctrl #(
  parameter int DW       = 8,
  parameter int WIN_BASE = 8'hF7,
  localparam int AW      = 2 * DW,
  localparam int DEPTH   = ((1 << DW) - WIN_BASE) << DW,
  localparam int IW      = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          wr_en,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  input  logic          sfr_port_we,
  input  logic          sfr_page_we,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] port_q,
  input  logic          xram_en,
  input  logic          dbg_en,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_dout,
  output logic          ext_doe,
  input  logic [DW-1:0] ext_din,
  output logic          ext_rd_n,
  output logic          ext_wr_n
);
  logic [DW-1:0] page_q;
  logic [DW-1:0] ram_rdata;
  logic [DW-1:0] ram_wdata;
  logic [IW-1:0] ram_addr;
  logic          ram_we;

  pxd_page_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .port_we(sfr_port_we), .page_we(sfr_page_we),
    .din(sfr_wdata), .page_q(page_q), .port_q(port_q)
  );

  pxd_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  pxd_seq #(.DW(DW), .WIN_BASE(WIN_BASE)) u_seq (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .ptr(ptr),
    .wdata(wdata), .page(page_q), .xram_en(xram_en), .dbg_en(dbg_en),
    .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .rdata(rdata), .done(done),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .ext_din(ext_din), .rd_n(ext_rd_n), .wr_n(ext_wr_n)
  );
endmodule

// File: tb/paged_xdata_ctrl_test.sv
`timescale 1ns/1ps
module paged_xdata_ctrl_test;
  logic clk = 1'b0;
  logic rst, req, wr_en, sfr_port_we, sfr_page_we, xram_en, dbg_en;
  logic [7:0] ptr, wdata, rdata, sfr_wdata, port_q, ext_dout, ext_din;
  logic done, ext_doe, ext_rd_n, ext_wr_n;
  logic [15:0] ext_addr;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  paged_xdata_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .wr_en(wr_en), .ptr(ptr), .wdata(wdata),
    .rdata(rdata), .done(done), .sfr_port_we(sfr_port_we),
    .sfr_page_we(sfr_page_we), .sfr_wdata(sfr_wdata), .port_q(port_q),
    .xram_en(xram_en), .dbg_en(dbg_en), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
  );

  typedef struct packed {
    logic       use_port;
    logic [7:0] page;
    logic [7:0] ptr;
    logic       we;
    logic [7:0] wd;
    logic [7:0] din;
    logic       internal;
    logic [7:0] exp_rd;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b1, 8'hF7, 8'h10, 1'b1, 8'hA5, 8'h00, 1'b1, 8'h00},
    '{1'b0, 8'hF7, 8'h10, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA5},
    '{1'b0, 8'h12, 8'h34, 1'b1, 8'h3C, 8'h00, 1'b0, 8'h00},
    '{1'b1, 8'h80, 8'h01, 1'b0, 8'h00, 8'h5A, 1'b0, 8'h5A},
    '{1'b0, 8'hFF, 8'hFF, 1'b1, 8'hC3, 8'h00, 1'b1, 8'h00},
    '{1'b0, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h99, 1'b1, 8'hC3},
    '{1'b0, 8'hF6, 8'h00, 1'b0, 8'h00, 8'h77, 1'b0, 8'h77}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic set_page(input bit via_port, input logic [7:0] v);
    sfr_wdata = v;
    if (via_port) sfr_port_we = 1'b1; else sfr_page_we = 1'b1;
    @(negedge clk);
    sfr_port_we = 1'b0;
    sfr_page_we = 1'b0;
  endtask

  // full move; checks bus in cycle 1 and done/rdata at the end
  task automatic move(input logic we, input logic [7:0] p, input logic [7:0] wd,
                      input logic [7:0] din, input bit internal,
                      input logic [15:0] exp_addr, input logic [7:0] exp_rd,
                      input string rq);
    logic exp_rdn, exp_wrn, exp_oe;
    req = 1'b1; wr_en = we; ptr = p; wdata = wd; ext_din = din;
    @(negedge clk);
    req = 1'b0;
    exp_rdn = internal ? 1'b1 : we;
    exp_wrn = internal ? 1'b1 : !we;
    exp_oe  = internal ? (dbg_en && we) : we;
    chk(ext_rd_n == exp_rdn, rq, 32'(ext_rd_n), 32'(exp_rdn));
    chk(ext_wr_n == exp_wrn, rq, 32'(ext_wr_n), 32'(exp_wrn));
    chk(ext_doe == exp_oe, rq, 32'(ext_doe), 32'(exp_oe));
    if (!internal) chk(ext_addr == exp_addr, rq, 32'(ext_addr), 32'(exp_addr));
    if (exp_oe) chk(ext_dout == wd, rq, 32'(ext_dout), 32'(wd));
    @(negedge clk);
    chk(done == 1'b0, {rq, " R11 early"}, 32'(done), 32'd0);
    @(negedge clk);
    chk(done == 1'b1, {rq, " R11 done"}, 32'(done), 32'd1);
    if (!we) chk(rdata == exp_rd, rq, 32'(rdata), 32'(exp_rd));
    @(negedge clk);
    chk(done == 1'b0 && ext_rd_n && ext_wr_n, {rq, " R11 pulse"},
        {30'd0, done, ext_rd_n & ext_wr_n}, 32'd1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; wr_en = 1'b0; ptr = '0; wdata = '0;
    sfr_port_we = 1'b0; sfr_page_we = 1'b0; sfr_wdata = '0;
    xram_en = 1'b1; dbg_en = 1'b0; ext_din = '0;
    repeat (3) @(negedge clk);
    chk(ext_rd_n && ext_wr_n && !ext_doe && !done, "R1 reset outputs",
        {28'd0, ext_rd_n, ext_wr_n, ext_doe, done}, 32'hC);
    rst = 1'b0;
    @(negedge clk);
    // R1: page is 0 after reset -> external at {00,ptr}
    move(1'b0, 8'h42, 8'h00, 8'h6E, 1'b0, 16'h0042, 8'h6E, "R1 first move external");

    // vector table: R2 R4 R5 R6
    for (int i = 0; i < 7; i++) begin
      set_page(VECS[i].use_port, VECS[i].page);
      move(VECS[i].we, VECS[i].ptr, VECS[i].wd, VECS[i].din, VECS[i].internal,
           {VECS[i].page, VECS[i].ptr}, VECS[i].exp_rd,
           $sformatf("R2/R4/R5/R6 vec%0d", i));
    end

    // R3: port write loads port_q and page; page write leaves port_q
    set_page(1'b1, 8'h55);
    chk(port_q == 8'h55, "R3 port value", 32'(port_q), 32'h55);
    set_page(1'b0, 8'h66);
    chk(port_q == 8'h55, "R3 page write keeps port", 32'(port_q), 32'h55);
    move(1'b0, 8'h07, 8'h00, 8'h12, 1'b0, 16'h6607, 8'h12, "R3 page used");

    // R2: window disabled -> external even at F7
    xram_en = 1'b0;
    set_page(1'b0, 8'hF7);
    move(1'b0, 8'h10, 8'h00, 8'hE1, 1'b0, 16'hF710, 8'hE1, "R2 xram_en off");
    xram_en = 1'b1;

    // R7: debug mirroring of an internal write
    dbg_en = 1'b1;
    move(1'b1, 8'h20, 8'h4D, 8'h00, 1'b1, 16'hF720, 8'h00, "R7 debug mirror");
    dbg_en = 1'b0;
    move(1'b0, 8'h20, 8'h00, 8'h00, 1'b1, 16'hF720, 8'h4D, "R7 data stored");

    // R8: reset in first cycle keeps old value
    set_page(1'b0, 8'hF8);
    move(1'b1, 8'h30, 8'h11, 8'h00, 1'b1, 16'hF830, 8'h00, "R8 seed");
    req = 1'b1; wr_en = 1'b1; ptr = 8'h30; wdata = 8'h22;
    @(negedge clk);
    req = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(done == 1'b0 && ext_rd_n, "R8 aborted", {30'd0, done, ext_rd_n}, 32'd1);
    set_page(1'b0, 8'hF8);
    move(1'b0, 8'h30, 8'h00, 8'h00, 1'b1, 16'hF830, 8'h11, "R8 R10 old value kept");

    // R9: reset in second cycle commits new value
    req = 1'b1; wr_en = 1'b1; ptr = 8'h30; wdata = 8'h33;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_page(1'b0, 8'hF8);
    move(1'b0, 8'h30, 8'h00, 8'h00, 1'b1, 16'hF830, 8'h33, "R9 R10 new value stored");

    // R11: req during a busy move is ignored
    set_page(1'b0, 8'h01);
    req = 1'b1; wr_en = 1'b0; ptr = 8'hAA; ext_din = 8'h3E;
    @(negedge clk);
    ptr = 8'hBB;                  // req still high while busy
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && rdata == 8'h3E, "R11 busy move done",
        {23'd0, done, rdata}, 32'h13E);
    @(negedge clk);
    chk(done == 1'b0 && ext_rd_n == 1'b1, "R11 second req ignored",
        {30'd0, done, ext_rd_n}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0 && ext_rd_n == 1'b1, "R11 no late move",
        {30'd0, done, ext_rd_n}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule